// File: doc/BRIEF.md
# Descriptor-Chain DMA Segment Fetcher

This block is the front end of an internal DMA engine. Software hands it the first transfer segment and, optionally, a chain of further descriptors kept in memory. The block then offers one contiguous segment at a time, as an address and a length, to a downstream data mover. In chained mode, once a segment has been accepted, the block reads the next descriptor through a simple one-read-at-a-time memory port. It reloads only the fields that the current link word asks for, and it stops after the segment whose link word does not request a further link.

Each descriptor occupies three consecutive 32-bit words. The link word is at offset +0, the buffer base at +4 and the buffer size at +8. In the link word, bits [OFS_W-1:0] give the byte offset of the next descriptor from the list base. Bit 31 requests a link reload and marks the chain as continuing, bit 30 requests a size reload and bit 29 requests a base reload. Software writes the list base, link, base and size registers through `cfg_sel` (0 list base, 1 link, 2 base, 3 size). It then writes the control strobe with `ctrl_en`=1 and `ctrl_ll` selecting chained mode. Writing the control strobe with `ctrl_en`=0 stops the engine at once.

The segment output follows valid/ready rules. While `seg_valid` is high and `seg_ready` is low, the address, length and last flag stay unchanged, and the block issues no memory read. A segment counts as transferred only on a cycle in which both signals are high. Downstream may hold `seg_ready` low for as long as it needs.

Top module: `sgdma_fetch`

## Requirements
- R1: After reset, `seg_valid`, `busy`, `err` and `mem_req` are all low.
- R2: In single-buffer mode (`ctrl_ll`=0), exactly one segment is offered, carrying the base and size registers with `seg_last`=1. The block makes no memory read, and `busy` falls after that segment is accepted. `seg_valid` rises on the second clock edge after the enabling control write.
- R3: In chained mode, segments appear in chain order. Each next descriptor is read from the list base plus link bits [OFS_W-1:0], with the words at +0 (link), +4 (base) and +8 (size). A segment whose link word has bit 31 clear is offered with `seg_last`=1 and ends the run.
- R4: During a descriptor fetch, a field whose flag in the current link word is clear keeps its previous value and its word is not read. Bit 30 controls the size field and bit 29 controls the base field.
- R5: While a segment waits for `seg_ready`, `seg_valid`, `seg_addr`, `seg_len` and `seg_last` hold steady and `mem_req` stays low.
- R6: A segment base with either of bits [1:0] set raises `err`, and the segment is never offered. `busy` falls, and `err` stays high until the next enabling control write clears it.
- R7: In chained mode, a segment that is not the last must have a size that is a multiple of SIZE_ALIGN, or `err` is raised as in R6. The last segment's size is unconstrained.
- R8: A control write with `ctrl_en`=0 drops `seg_valid` and `busy` on the next clock edge, from any state.
- R9: Configuration writes made while `busy` is high have no effect, and the segment on offer keeps its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 list base, 1 link, 2 base, 3 size |
| cfg_wdata | input | 32 | Configuration write data |
| ctrl_we | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable value written (0 = stop) |
| ctrl_ll | input | 1 | Chained-mode enable written with the control strobe |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | AW | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| seg_valid | output | 1 | Segment on offer |
| seg_ready | input | 1 | Downstream accepts the segment |
| seg_addr | output | AW | Segment base address |
| seg_len | output | 32 | Segment length in bytes |
| seg_last | output | 1 | Segment is the final one of the run |
| busy | output | 1 | Engine is running |
| err | output | 1 | Alignment error, sticky until next enable |

## Verification
An enabling control write is seen on one edge, which moves the engine to the check state. `seg_valid` or `err` then changes on the following edge, so the bench samples both on the falling edge after the second rising edge. An acceptance or a stop write takes effect on the next rising edge, and `busy` and `seg_valid` are checked on the falling edge that follows. Descriptor fetches take a variable number of cycles, so for those the bench waits for `seg_valid` with a bounded poll, and it compares memory-read counts taken at the port against the number of flagged words.

// File: rtl/sgdma_pkg.sv
`timescale 1ns/1ps
package sgdma_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FLG_LINK = 31;
  localparam int unsigned FLG_SIZE = 30;
  localparam int unsigned FLG_BASE = 29;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_ISSUE = 2'd2,
    ST_FETCH = 2'd3
  } eng_state_t;

  typedef enum logic [1:0] {
    SEL_LIST = 2'd0,
    SEL_LINK = 2'd1,
    SEL_BASE = 2'd2,
    SEL_SIZE = 2'd3
  } cfg_sel_t;

  typedef struct packed {
    logic link;
    logic size;
    logic base;
  } upd_flags_t;

  function automatic upd_flags_t decode_flags(input logic [WORD_W-1:0] w);
    upd_flags_t f;
    f.link = w[FLG_LINK];
    f.size = w[FLG_SIZE];
    f.base = w[FLG_BASE];
    return f;
  endfunction
endpackage

// File: rtl/sgdma_desc_regs.sv
`timescale 1ns/1ps
module sgdma_desc_regs
  import sgdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              ld_link,
  input  logic              ld_base,
  input  logic              ld_size,
  input  logic [WORD_W-1:0] ld_data,
  output logic [AW-1:0]     list_base,
  output logic [WORD_W-1:0] link_w,
  output logic [AW-1:0]     base_w,
  output logic [WORD_W-1:0] size_w
);
  logic sw_wr;
  assign sw_wr = idle && cfg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      list_base <= '0;
      link_w    <= '0;
      base_w    <= '0;
      size_w    <= '0;
    end else if (sw_wr) begin
      case (cfg_sel_t'(cfg_sel))
        SEL_LIST: list_base <= cfg_wdata[AW-1:0];
        SEL_LINK: link_w    <= cfg_wdata;
        SEL_BASE: base_w    <= cfg_wdata[AW-1:0];
        SEL_SIZE: size_w    <= cfg_wdata;
        default:  ;
      endcase
    end else begin
      if (ld_link) link_w <= ld_data;
      if (ld_base) base_w <= ld_data[AW-1:0];
      if (ld_size) size_w <= ld_data;
    end
  end

  // R9: outside idle, the base only moves on a descriptor load
  a_r9_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !ld_base) |=> $stable(base_w));

  // R4: the size field only changes on a flagged load while running
  a_r4_size_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !ld_size) |=> $stable(size_w));
endmodule

// File: rtl/sgdma_desc_rd.sv
`timescale 1ns/1ps
module sgdma_desc_rd
  import sgdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [AW-1:0]     desc_addr,
  input  upd_flags_t        flags,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              ld_link,
  output logic              ld_base,
  output logic              ld_size,
  output logic [WORD_W-1:0] ld_data,
  output logic              done
);
  localparam logic [1:0] IDX_LAST = 2'd2;

  logic       active, waiting;
  logic [1:0] idx;
  upd_flags_t flg_q;
  logic [AW-1:0] addr_q;
  logic need, got, step;

  always_comb begin
    case (idx)
      2'd0:    need = flg_q.link;
      2'd1:    need = flg_q.base;
      default: need = flg_q.size;
    endcase
  end

  assign mem_req  = active && !waiting && need;
  assign mem_addr = addr_q + AW'({idx, 2'b00});
  assign got      = active && waiting && mem_rvalid;
  assign step     = got || (active && !waiting && !need);
  assign done     = step && (idx == IDX_LAST);
  assign ld_link  = got && (idx == 2'd0);
  assign ld_base  = got && (idx == 2'd1);
  assign ld_size  = got && (idx == 2'd2);
  assign ld_data  = mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      active  <= 1'b0;
      waiting <= 1'b0;
      idx     <= '0;
      flg_q   <= '0;
      addr_q  <= '0;
    end else if (start) begin
      active  <= 1'b1;
      waiting <= 1'b0;
      idx     <= '0;
      flg_q   <= flags;
      addr_q  <= desc_addr;
    end else begin
      if (mem_req) waiting <= 1'b1;
      if (got)     waiting <= 1'b0;
      if (step) begin
        if (idx == IDX_LAST) active <= 1'b0;
        else                 idx    <= idx + 2'd1;
      end
    end
  end

  // R3: one outstanding read; a request is never repeated back to back
  a_r3_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R3: descriptor words are fetched on word boundaries relative to the start
  a_r3_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !abort) |=> $stable(addr_q));
endmodule

// File: rtl/sgdma_align_chk.sv
`timescale 1ns/1ps
module sgdma_align_chk
  import sgdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SIZE_ALIGN = 32
) (
  input  logic [AW-1:0]     base,
  input  logic [WORD_W-1:0] size,
  input  logic              is_last,
  output logic              base_bad,
  output logic              size_bad
);
  localparam logic [WORD_W-1:0] SIZE_MASK = WORD_W'(SIZE_ALIGN - 1);

  assign base_bad = |base[1:0];
  assign size_bad = !is_last && ((size & SIZE_MASK) != '0);
endmodule

// File: rtl/sgdma_fetch.sv
`timescale 1ns/1ps
module sgdma_fetch
  import sgdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int OFS_W      = 16,
  parameter int SIZE_ALIGN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              ctrl_we,
  input  logic              ctrl_en,
  input  logic              ctrl_ll,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [AW-1:0]     seg_addr,
  output logic [31:0]       seg_len,
  output logic              seg_last,
  output logic              busy,
  output logic              err
);
  eng_state_t state;
  logic ll_q, err_q;
  logic abort, go;
  logic [AW-1:0]     list_base, base_w, desc_addr;
  logic [WORD_W-1:0] link_w, size_w, ld_data;
  logic ld_link, ld_base, ld_size, fetch_done, fetch_start;
  logic base_bad, size_bad, is_last;
  upd_flags_t flags;
  logic unused_link_bits;

  assign abort   = ctrl_we && !ctrl_en;
  assign go      = ctrl_we && ctrl_en;
  assign flags   = decode_flags(link_w);
  assign is_last = !ll_q || !flags.link;
  assign desc_addr = list_base + AW'(link_w[OFS_W-1:0]);
  assign fetch_start = (state == ST_ISSUE) && seg_ready && !is_last && !abort;
  assign unused_link_bits = ^link_w[FLG_BASE-1:OFS_W];

  sgdma_desc_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .idle(state == ST_IDLE),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ld_link(ld_link), .ld_base(ld_base), .ld_size(ld_size), .ld_data(ld_data),
    .list_base(list_base), .link_w(link_w), .base_w(base_w), .size_w(size_w)
  );

  sgdma_desc_rd #(.AW(AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .start(fetch_start), .abort(abort),
    .desc_addr(desc_addr), .flags(flags),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_link(ld_link), .ld_base(ld_base), .ld_size(ld_size), .ld_data(ld_data),
    .done(fetch_done)
  );

  sgdma_align_chk #(.AW(AW), .SIZE_ALIGN(SIZE_ALIGN)) u_chk (
    .base(base_w), .size(size_w), .is_last(is_last),
    .base_bad(base_bad), .size_bad(size_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ll_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (abort) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          state <= ST_CHECK;
          ll_q  <= ctrl_ll;
          err_q <= 1'b0;
        end
        ST_CHECK: if (base_bad || size_bad) begin
          err_q <= 1'b1;
          state <= ST_IDLE;
        end else begin
          state <= ST_ISSUE;
        end
        ST_ISSUE: if (seg_ready) state <= is_last ? ST_IDLE : ST_FETCH;
        ST_FETCH: if (fetch_done) state <= ST_CHECK;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign seg_valid = (state == ST_ISSUE);
  assign seg_addr  = base_w;
  assign seg_len   = size_w;
  assign seg_last  = is_last;
  assign busy      = (state != ST_IDLE);
  assign err       = err_q;

  // R5: an offered segment holds until taken
  a_r5_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready && !abort) |=>
      (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_last)));

  // R5: no descriptor read while a segment is on offer
  a_r5_no_read_offered: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !mem_req);

  // R8: a stop write idles the engine on the next edge
  a_r8_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !seg_valid));

  // R6: an error never coincides with an offered segment
  a_r6_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (!seg_valid && !busy));

  // R2: single-buffer runs never touch memory
  a_r2_single_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ll_q) |-> !mem_req);
endmodule

// File: tb/sgdma_fetch_test.sv
`timescale 1ns/1ps
module sgdma_fetch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic ctrl_we = 1'b0, ctrl_en = 1'b0, ctrl_ll = 1'b0;
  logic mem_req, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic seg_valid, seg_ready, seg_last, busy, err;
  logic [31:0] seg_addr, seg_len;
  logic [31:0] mem [0:63];
  int rd_count = 0;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sgdma_fetch uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_we(ctrl_we), .ctrl_en(ctrl_en), .ctrl_ll(ctrl_ll),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .seg_last(seg_last), .busy(busy), .err(err)
  );

  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    seg_ready  = 1'b0;
  end

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem[mem_addr[7:2]];
    if (mem_req) rd_count <= rd_count + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctrl(input logic en, input logic ll);
    ctrl_we = 1'b1; ctrl_en = en; ctrl_ll = ll;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic take_seg(input logic [31:0] a, input logic [31:0] l, input logic last, input string tag);
    int n = 0;
    while (!seg_valid && n < 40) begin @(negedge clk); n++; end
    chk(seg_valid, {tag, " valid"}, 32'(seg_valid), 32'd1);
    chk(seg_addr == a, {tag, " addr"}, seg_addr, a);
    chk(seg_len == l, {tag, " len"}, seg_len, l);
    chk(seg_last == last, {tag, " last"}, 32'(seg_last), 32'(last));
    seg_ready = 1'b1;
    @(negedge clk);
    seg_ready = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk(!seg_valid && !busy && !err && !mem_req, "R1 reset state",
        {28'd0, seg_valid, busy, err, mem_req}, 32'd0);
  endtask

  task automatic t_single();
    int r0 = rd_count;
    cfg(2'd2, 32'h0000_1000);
    cfg(2'd3, 32'h0000_0023);
    ctrl(1'b1, 1'b0);
    chk(!seg_valid && busy, "R2 one edge after enable", 32'(seg_valid), 32'd0);
    @(negedge clk);
    chk(seg_valid, "R2 valid on second edge", 32'(seg_valid), 32'd1);
    take_seg(32'h1000, 32'h23, 1'b1, "R2 single");
    chk(!busy, "R2 idle after accept", 32'(busy), 32'd0);
    chk(rd_count == r0, "R2 no reads", 32'(rd_count - r0), 32'd0);
  endtask

  task automatic t_chain();
    int r0;
    mem[16] = 32'hE000_000C; mem[17] = 32'h0000_2000; mem[18] = 32'h0000_0040;
    mem[19] = 32'hE000_0018; mem[20] = 32'h0000_3000; mem[21] = 32'h0000_0080;
    mem[22] = 32'h6000_0024; mem[23] = 32'h0000_4000; mem[24] = 32'h0000_0013;
    cfg(2'd0, 32'h0000_0040);
    cfg(2'd1, 32'hE000_000C);
    cfg(2'd2, 32'h0000_2000);
    cfg(2'd3, 32'h0000_0040);
    ctrl(1'b1, 1'b1);
    @(negedge clk);
    r0 = rd_count;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(seg_valid && seg_addr == 32'h2000, "R5 held under back-pressure", seg_addr, 32'h2000);
    end
    chk(rd_count == r0, "R5 no read while offered", 32'(rd_count - r0), 32'd0);
    take_seg(32'h2000, 32'h40, 1'b0, "R3 seg0");
    take_seg(32'h3000, 32'h80, 1'b0, "R3 seg1");
    take_seg(32'h4000, 32'h13, 1'b1, "R3 seg2 R7 last unaligned");
    chk(!busy && !err, "R3 chain ended", {30'd0, busy, err}, 32'd0);
    chk(rd_count - r0 == 6, "R3 read count", 32'(rd_count - r0), 32'd6);
  endtask

  task automatic t_partial();
    int r0;
    mem[32] = 32'h0000_0000; mem[33] = 32'h0000_5000; mem[34] = 32'hFFFF_FFF0;
    cfg(2'd0, 32'h0000_0080);
    cfg(2'd1, 32'hA000_0000);
    cfg(2'd2, 32'h0000_4800);
    cfg(2'd3, 32'h0000_0020);
    r0 = rd_count;
    ctrl(1'b1, 1'b1);
    take_seg(32'h4800, 32'h20, 1'b0, "R4 first");
    take_seg(32'h5000, 32'h20, 1'b1, "R4 size kept");
    chk(rd_count - r0 == 2, "R4 unflagged word not read", 32'(rd_count - r0), 32'd2);
  endtask

  task automatic t_bad_base();
    cfg(2'd2, 32'h0000_1002);
    cfg(2'd3, 32'h0000_0004);
    ctrl(1'b1, 1'b0);
    @(negedge clk);
    chk(err && !seg_valid && !busy, "R6 misaligned base", {29'd0, err, seg_valid, busy}, 32'd4);
    cfg(2'd2, 32'h0000_1004);
    ctrl(1'b1, 1'b0);
    chk(!err, "R6 err cleared by enable", 32'(err), 32'd0);
    take_seg(32'h1004, 32'h4, 1'b1, "R6 recovery");
  endtask

  task automatic t_bad_size();
    cfg(2'd1, 32'h8000_0000);
    cfg(2'd2, 32'h0000_2000);
    cfg(2'd3, 32'h0000_0021);
    ctrl(1'b1, 1'b1);
    @(negedge clk);
    chk(err && !seg_valid && !busy, "R7 unaligned non-last size", {29'd0, err, seg_valid, busy}, 32'd4);
  endtask

  task automatic t_abort();
    cfg(2'd2, 32'h0000_6000);
    cfg(2'd3, 32'h0000_0010);
    ctrl(1'b1, 1'b0);
    @(negedge clk);
    chk(seg_valid, "R8 offered before stop", 32'(seg_valid), 32'd1);
    ctrl(1'b0, 1'b0);
    chk(!seg_valid && !busy, "R8 stop drops valid", {30'd0, seg_valid, busy}, 32'd0);
  endtask

  task automatic t_busy_write();
    cfg(2'd2, 32'h0000_6000);
    cfg(2'd3, 32'h0000_0010);
    ctrl(1'b1, 1'b0);
    @(negedge clk);
    cfg(2'd2, 32'h0000_7000);
    chk(seg_addr == 32'h6000, "R9 write while busy ignored", seg_addr, 32'h6000);
    take_seg(32'h6000, 32'h10, 1'b1, "R9 segment intact");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_chain();
    t_partial();
    t_bad_base();
    t_bad_size();
    t_abort();
    t_busy_write();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end
endmodule